// File: doc/BRIEF.md
# Nibble-Loaded Character Bank Mapper

This block is one banking personality of a cartridge mapper. It watches CPU writes in the upper half of the address space. From them it keeps two 8 KB program bank registers, one mirroring register and eight 1 KB character bank registers. Its outputs are the bank numbers that the memory arrays need.

Each character register is loaded four bits at a time. Address bit 0 picks which half of the register a write replaces. The register index comes from the upper address bits combined with address bit 1.

The personality responds only while the two low bits of the mode byte are both zero. Bit 2 of the mode byte adds bank bit 8 to every character bank number. The mode register itself lives outside this block, which receives its three low bits.

Top module: `nib_chr_mapper`

## Requirements
- R1: After reset, character registers 0 to 7 hold the values 0 to 7, program register 0 holds 0, program register 1 holds 1, and the mirroring output is 0.
- R2: An enabled write to an address from 0xB000 through 0xE003 loads character register ((((A & 2) | (A >> 10)) >> 1) + 2) mod 8. For example, 0xB000 loads register 0, 0xB002 register 1, 0xC000 register 2, 0xD000 register 4, 0xE002 register 7, and 0xE003 register 7.
- R3: In such a write, address bit 0 = 0 puts data bits 3:0 into register bits 3:0. Address bit 0 = 1 puts data bits 3:0 into register bits 7:4. The other half of the register keeps its value.
- R4: Outside the character range, an enabled write with A[15:12] = 0x8 loads program register 0 with the full data byte. A[15:12] = 0xA loads program register 1. Program slots 0 and 1 output these registers.
- R5: Program slot 2 always outputs bank 0x1E and program slot 3 always outputs bank 0x1F.
- R6: Outside the character range, an enabled write with A[15:12] = 0x9 stores data bit 0 as the mirroring output. The value 1 means horizontal mirroring and 0 means vertical mirroring.
- R7: Each character bank output is 9 bits wide. Bits 7:0 are the register value and bit 8 equals mode bit 2.
- R8: A write while mode bits 1:0 are not 00 changes no register. The outputs keep their values for as long as another mode is active.
- R9: Writes below 0x8000 and writes from 0xE004 through 0xFFFF change no register.
- R10: A write takes effect on the outputs after the rising clock edge that samples it. Before that edge the outputs still show the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU write address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, one cycle per write |
| mode_lo | input | 3 | Low three bits of the mode byte |
| prg_bank_o | output | 32 | Four 8-bit program bank numbers, slot 0 in bits 7:0 |
| chr_bank_o | output | 72 | Eight 9-bit character bank numbers, slot 0 in bits 8:0 |
| mirror_horiz_o | output | 1 | 1 = horizontal mirroring, 0 = vertical mirroring |

## Verification
Every register write is due on the outputs one rising edge after the cycle that carries the strobe. Changing mode bit 2 moves character bank bit 8 at once, with no clock edge. The bench drives inputs just after a falling edge. It checks that the outputs still show the old values before the edge. The scoreboard then compares the new values at the next falling edge, and the bench holds the mode steady across that edge so that each comparison sees a single cause.

// File: rtl/nib_map_pkg.sv
package nib_map_pkg;
    localparam int BANK_W    = 8;
    localparam int CHR_IDX_W = 3;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_CHR,
        TGT_PRG0,
        TGT_PRG1,
        TGT_MIRR
    } wr_tgt_e;

    typedef struct packed {
        wr_tgt_e               tgt;
        logic [CHR_IDX_W-1:0]  idx;
        logic                  hi_nib;
        logic [BANK_W-1:0]     data;
    } wr_cmd_t;
endpackage

// File: rtl/nib_map_decode.sv
module nib_map_decode
    import nib_map_pkg::*;
#(
    parameter logic [15:0] CHR_LO = 16'hB000,
    parameter logic [15:0] CHR_HI = 16'hE003
) (
    input  logic [15:0]       cpu_addr,
    input  logic [BANK_W-1:0] cpu_data,
    input  logic              cpu_wr,
    input  logic [1:0]        mode_sel,
    output wr_cmd_t           cmd
);
    logic enable;
    logic in_chr;

    always_comb begin
        enable     = cpu_wr && (mode_sel == 2'b00) && cpu_addr[15];
        in_chr     = (cpu_addr >= CHR_LO) && (cpu_addr <= CHR_HI);
        cmd        = '0;
        cmd.tgt    = TGT_NONE;
        cmd.data   = cpu_data;
        cmd.hi_nib = cpu_addr[0];
        cmd.idx    = {cpu_addr[13], cpu_addr[12], cpu_addr[11] | cpu_addr[1]} + 3'd2;
        if (enable) begin
            if (in_chr) begin
                cmd.tgt = TGT_CHR;
            end else begin
                case (cpu_addr[14:12])
                    3'h0:    cmd.tgt = TGT_PRG0;
                    3'h2:    cmd.tgt = TGT_PRG1;
                    3'h1:    cmd.tgt = TGT_MIRR;
                    default: cmd.tgt = TGT_NONE;
                endcase
            end
        end
    end
endmodule

// File: rtl/nib_map_regs.sv
module nib_map_regs
    import nib_map_pkg::*;
#(
    parameter int NUM_CHR = 8,
    parameter int NUM_PRG = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  wr_cmd_t                          cmd,
    output logic [NUM_CHR-1:0][BANK_W-1:0]   chr_q,
    output logic [NUM_PRG-1:0][BANK_W-1:0]   prg_q,
    output logic                             mirr_q
);
    localparam int NIB_W = BANK_W / 2;

    typedef struct packed {
        logic [NUM_CHR-1:0][BANK_W-1:0] chr;
        logic [NUM_PRG-1:0][BANK_W-1:0] prg;
        logic                           mirr;
    } state_t;

    function automatic state_t reset_state();
        state_t s;
        s = '0;
        for (int i = 0; i < NUM_CHR; i++) begin
            s.chr[i] = BANK_W'(i);
        end
        for (int j = 0; j < NUM_PRG; j++) begin
            s.prg[j] = BANK_W'(j);
        end
        s.mirr = 1'b0;
        return s;
    endfunction

    localparam state_t RST_STATE = reset_state();

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (cmd.tgt)
            TGT_CHR: begin
                if (cmd.hi_nib) begin
                    st_d.chr[cmd.idx][2*NIB_W-1:NIB_W] = cmd.data[NIB_W-1:0];
                end else begin
                    st_d.chr[cmd.idx][NIB_W-1:0] = cmd.data[NIB_W-1:0];
                end
            end
            TGT_PRG0: st_d.prg[0] = cmd.data;
            TGT_PRG1: st_d.prg[1] = cmd.data;
            TGT_MIRR: st_d.mirr   = cmd.data[0];
            default:  ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= RST_STATE;
        end else begin
            st_q <= st_d;
        end
    end

    assign chr_q  = st_q.chr;
    assign prg_q  = st_q.prg;
    assign mirr_q = st_q.mirr;
endmodule

// File: rtl/nib_map_banks.sv
module nib_map_banks
    import nib_map_pkg::*;
#(
    parameter int                NUM_CHR    = 8,
    parameter int                NUM_PRG    = 2,
    parameter int                PRG_SLOTS  = 4,
    parameter logic [BANK_W-1:0] FIXED_BASE = 8'h1E
) (
    input  logic [NUM_CHR-1:0][BANK_W-1:0]   chr_q,
    input  logic [NUM_PRG-1:0][BANK_W-1:0]   prg_q,
    input  logic                             mirr_q,
    input  logic                             chr_hi,
    output logic [PRG_SLOTS-1:0][BANK_W-1:0] prg_bank,
    output logic [NUM_CHR-1:0][BANK_W:0]     chr_bank,
    output logic                             mirror_horiz
);
    for (genvar c = 0; c < NUM_CHR; c++) begin : g_chr
        assign chr_bank[c] = {chr_hi, chr_q[c]};
    end

    for (genvar s = 0; s < PRG_SLOTS; s++) begin : g_prg
        if (s < NUM_PRG) begin : g_sw
            assign prg_bank[s] = prg_q[s];
        end else begin : g_fix
            assign prg_bank[s] = FIXED_BASE + BANK_W'(s - NUM_PRG);
        end
    end

    assign mirror_horiz = mirr_q;
endmodule

// File: rtl/nib_chr_mapper.sv
module nib_chr_mapper
    import nib_map_pkg::*;
#(
    parameter int NUM_CHR   = 8,
    parameter int NUM_PRG   = 2,
    parameter int PRG_SLOTS = 4,
    parameter int PRG_OUT_W = PRG_SLOTS * BANK_W,
    parameter int CHR_OUT_W = NUM_CHR * (BANK_W + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [15:0]          cpu_addr,
    input  logic [BANK_W-1:0]    cpu_data,
    input  logic                 cpu_wr,
    input  logic [2:0]           mode_lo,
    output logic [PRG_OUT_W-1:0] prg_bank_o,
    output logic [CHR_OUT_W-1:0] chr_bank_o,
    output logic                 mirror_horiz_o
);
    wr_cmd_t                          cmd;
    logic [NUM_CHR-1:0][BANK_W-1:0]   chr_q;
    logic [NUM_PRG-1:0][BANK_W-1:0]   prg_q;
    logic                             mirr_q;
    logic [PRG_SLOTS-1:0][BANK_W-1:0] prg_bank;
    logic [NUM_CHR-1:0][BANK_W:0]     chr_bank;

    nib_map_decode u_dec (
        .cpu_addr (cpu_addr),
        .cpu_data (cpu_data),
        .cpu_wr   (cpu_wr),
        .mode_sel (mode_lo[1:0]),
        .cmd      (cmd)
    );

    nib_map_regs #(.NUM_CHR(NUM_CHR), .NUM_PRG(NUM_PRG)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd    (cmd),
        .chr_q  (chr_q),
        .prg_q  (prg_q),
        .mirr_q (mirr_q)
    );

    nib_map_banks #(.NUM_CHR(NUM_CHR), .NUM_PRG(NUM_PRG), .PRG_SLOTS(PRG_SLOTS)) u_banks (
        .chr_q        (chr_q),
        .prg_q        (prg_q),
        .mirr_q       (mirr_q),
        .chr_hi       (mode_lo[2]),
        .prg_bank     (prg_bank),
        .chr_bank     (chr_bank),
        .mirror_horiz (mirror_horiz_o)
    );

    assign prg_bank_o = prg_bank;
    assign chr_bank_o = chr_bank;
endmodule

// File: rtl/nib_chr_mapper_chk.sv
module nib_chr_mapper_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] cpu_addr,
    input logic [7:0]  cpu_data,
    input logic        cpu_wr,
    input logic [2:0]  mode_lo,
    input logic [31:0] prg_bank_o,
    input logic [71:0] chr_bank_o,
    input logic        mirror_horiz_o
);
    // R8
    other_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && mode_lo[1:0] != 2'b00) |=> ($stable(prg_bank_o) && $stable(mirror_horiz_o)));

    // R9
    low_addr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !cpu_addr[15]) |=> ($stable(prg_bank_o) && $stable(mirror_horiz_o)));

    // R4
    prg0_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && mode_lo[1:0] == 2'b00 && cpu_addr[15:12] == 4'h8)
        |=> (prg_bank_o[7:0] == $past(cpu_data)));

    // R6
    mirror_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && mode_lo[1:0] == 2'b00 && cpu_addr[15:12] == 4'h9)
        |=> (mirror_horiz_o == $past(cpu_data[0])));

    // R3
    low_nibble_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && mode_lo[1:0] == 2'b00 && cpu_addr == 16'hB000)
        |=> (chr_bank_o[3:0] == $past(cpu_data[3:0]) && chr_bank_o[7:4] == $past(chr_bank_o[7:4])));
endmodule

bind nib_chr_mapper nib_chr_mapper_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cpu_addr       (cpu_addr),
    .cpu_data       (cpu_data),
    .cpu_wr         (cpu_wr),
    .mode_lo        (mode_lo),
    .prg_bank_o     (prg_bank_o),
    .chr_bank_o     (chr_bank_o),
    .mirror_horiz_o (mirror_horiz_o)
);

// File: tb/tb_nib_chr_mapper.sv
`timescale 1ns/1ps
module tb_nib_chr_mapper;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] cpu_addr;
    logic [7:0]  cpu_data;
    logic        cpu_wr;
    logic [2:0]  mode_lo;
    logic [31:0] prg_bank_o;
    logic [71:0] chr_bank_o;
    logic        mirror_horiz_o;

    always #4 clk = ~clk;

    nib_chr_mapper dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cpu_addr       (cpu_addr),
        .cpu_data       (cpu_data),
        .cpu_wr         (cpu_wr),
        .mode_lo        (mode_lo),
        .prg_bank_o     (prg_bank_o),
        .chr_bank_o     (chr_bank_o),
        .mirror_horiz_o (mirror_horiz_o)
    );

    typedef struct {
        string       tag;
        logic [31:0] prg;
        logic [71:0] chr;
        logic        mir;
    } exp_t;

    exp_t        sb_q[$];
    int          n_checks = 0;
    int          n_errors = 0;
    bit          done = 0;
    logic [7:0]  m_chr [8];
    logic [7:0]  m_prg [2];
    logic        m_mir;
    logic [2:0]  m_mode;

    function automatic exp_t snap(string tag);
        exp_t e;
        e.tag = tag;
        e.prg = {8'h1F, 8'h1E, m_prg[1], m_prg[0]};
        for (int i = 0; i < 8; i++) e.chr[i*9 +: 9] = {m_mode[2], m_chr[i]};
        e.mir = m_mir;
        return e;
    endfunction

    task automatic compare(exp_t e);
        n_checks++;
        if (prg_bank_o !== e.prg) begin
            n_errors++;
            $display("FAIL %s prg actual=%h expected=%h", e.tag, prg_bank_o, e.prg);
        end
        n_checks++;
        if (chr_bank_o !== e.chr) begin
            n_errors++;
            $display("FAIL %s chr actual=%h expected=%h", e.tag, chr_bank_o, e.chr);
        end
        n_checks++;
        if (mirror_horiz_o !== e.mir) begin
            n_errors++;
            $display("FAIL %s mirror actual=%b expected=%b", e.tag, mirror_horiz_o, e.mir);
        end
    endtask

    function automatic void model_write(logic [15:0] a, logic [7:0] d);
        int idx;
        if (m_mode[1:0] == 2'b00 && a >= 16'h8000) begin
            if (a >= 16'hB000 && a <= 16'hE003) begin
                idx = (((int'(a) & 2) | (int'(a) >> 10)) >> 1) + 2;
                idx = idx & 7;
                if (a[0]) m_chr[idx][7:4] = d[3:0];
                else      m_chr[idx][3:0] = d[3:0];
            end else if (a[15:12] == 4'h8) m_prg[0] = d;
            else if (a[15:12] == 4'hA) m_prg[1] = d;
            else if (a[15:12] == 4'h9) m_mir = d[0];
        end
    endfunction

    // Drives one write; checks R10 before the edge and queues the result for after it.
    task automatic do_write(logic [15:0] a, logic [7:0] d, logic [2:0] md, string tag);
        exp_t pre;
        @(negedge clk);
        #1;
        m_mode   = md;
        mode_lo  = md;
        pre      = snap("R10 before edge");
        cpu_addr = a;
        cpu_data = d;
        cpu_wr   = 1'b1;
        #1;
        compare(pre);
        model_write(a, d);
        @(posedge clk);
        #1;
        cpu_wr = 1'b0;
        sb_q.push_back(snap(tag));
    endtask

    always @(negedge clk) begin
        if (sb_q.size() > 0) compare(sb_q.pop_front());
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cpu_addr = 16'h0; cpu_data = 8'h0; cpu_wr = 1'b0; mode_lo = 3'b000;
        for (int i = 0; i < 8; i++) m_chr[i] = 8'(i);
        m_prg[0] = 8'h00; m_prg[1] = 8'h01; m_mir = 1'b0; m_mode = 3'b000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        rst_n = 1'b1;
        sb_q.push_back(snap("R1 reset values"));
        // R3: nibble loads of register 0
        do_write(16'hB000, 8'h5A, 3'b000, "R3 low nibble");
        do_write(16'hB001, 8'h3C, 3'b000, "R3 high nibble");
        do_write(16'hB000, 8'hF1, 3'b000, "R3 low keeps high");
        // R2: index decode
        do_write(16'hB002, 8'h09, 3'b000, "R2 B002 reg1");
        do_write(16'hC000, 8'h0B, 3'b000, "R2 C000 reg2");
        do_write(16'hC002, 8'h0C, 3'b000, "R2 C002 reg3");
        do_write(16'hD000, 8'h0D, 3'b000, "R2 D000 reg4");
        do_write(16'hD003, 8'h0E, 3'b000, "R2 D003 reg5 high");
        do_write(16'hE000, 8'h06, 3'b000, "R2 E000 reg6");
        do_write(16'hE002, 8'h07, 3'b000, "R2 E002 reg7");
        do_write(16'hE003, 8'h08, 3'b000, "R2 E003 reg7 high");
        do_write(16'hB800, 8'h04, 3'b000, "R2 B800 alias reg1");
        // R4 and R5
        do_write(16'h8000, 8'h12, 3'b000, "R4 prg0 R5 fixed");
        do_write(16'hAFFF, 8'hC4, 3'b000, "R4 prg1 R5 fixed");
        // R6
        do_write(16'h9000, 8'h01, 3'b000, "R6 horizontal");
        do_write(16'h9ABC, 8'hFE, 3'b000, "R6 vertical");
        do_write(16'h9001, 8'h03, 3'b000, "R6 horizontal again");
        // R7
        do_write(16'h8123, 8'h55, 3'b100, "R7 chr bit8 set");
        do_write(16'hC001, 8'h0A, 3'b100, "R7 chr write high mode");
        // R8
        do_write(16'h8000, 8'h99, 3'b001, "R8 mode1 prg");
        do_write(16'hB000, 8'h07, 3'b010, "R8 mode2 chr");
        do_write(16'h9000, 8'h00, 3'b011, "R8 mode3 mirror");
        do_write(16'hA000, 8'h77, 3'b101, "R8 mode5 prg1");
        do_write(16'hE002, 8'h0F, 3'b110, "R8 mode6 chr7");
        // R9
        do_write(16'h7FFF, 8'hFF, 3'b000, "R9 below 8000");
        do_write(16'h4100, 8'h01, 3'b000, "R9 low mode port");
        do_write(16'hE004, 8'h0F, 3'b000, "R9 E004");
        do_write(16'hF000, 8'hAA, 3'b000, "R9 F000");
        do_write(16'hB000, 8'h02, 3'b000, "R3 final low nibble");
        while (sb_q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule